// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar in seven packed-BCD fields: seconds, minutes, hours in 24-hour form, day of week, date, month and a two-digit year. An upstream prescaler delivers a strobe a fixed number of times per second. The block counts those strobes into whole seconds and advances the calendar once per second. Carries ripple from seconds up to the year, and the date wraps at the end of each month. Month lengths follow the calendar, and February gains a 29th day whenever the two-digit year is a multiple of four.

A single load strobe writes all seven fields at once. Bit 7 of the seconds value is a stop flag that freezes counting while it is set. Both a load and a set stop flag restart the sub-second phase, so the first increment after a load, or after the stop flag is cleared, comes one full second later. A busy output is high during the cycle just before the fields change. A register layer outside the block uses it to avoid copying values in transition.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 0x80 (stop flag set, count 00), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, and busy_o is 0.
- R2: Every STEPS_PER_SEC strobes on step_i make one second. Seconds count 00..59 in packed BCD (high nibble tens, low nibble units) and wrap from 59 to 00 with a carry into minutes. Minutes wrap from 59 to 00 with a carry into hours.
- R3: Hours wrap from 23 to 00 and carry into both day and date. Day counts 01..07 and wraps from 07 to 01.
- R4: The last date is 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for every other month. On a carry, a date at or above the last date becomes 01 and carries into the month. A lower date increments.
- R5: February ends on 29 when the two-digit year is divisible by four (tens digit even and units 0, 4 or 8, or tens digit odd and units 2 or 6), and on 28 otherwise.
- R6: The month wraps from 12 to 01 with a carry into the year. The year wraps from 99 to 00.
- R7: Bit 7 of the seconds value is the stop flag. While it is 1, no field changes and busy_o stays 0. It is written only by a load.
- R8: When load_i is high, all seven fields and the stop flag take the load values at the next edge. Bits above each field's range are stored as 0: minutes keep bits 6:0, hours 5:0, day 2:0, date 5:0, month 4:0, and seconds bits 6:0 plus the stop flag. A load discards a pending increment and restarts the phase, so the next increment needs STEPS_PER_SEC further strobes.
- R9: busy_o is 1 for exactly one cycle, and the fields change at the edge that ends that cycle. Without busy_o or a load, the fields do not change.
- R10: After a load clears the stop flag, counting resumes after STEPS_PER_SEC strobes. Strobes given while the flag was set are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Sub-second strobe from the prescaler |
| load_i | input | 1 | Load all fields from the load inputs |
| load_sec_i | input | 8 | Seconds load value, bit 7 is the stop flag |
| load_min_i | input | 8 | Minutes load value |
| load_hour_i | input | 8 | Hours load value |
| load_day_i | input | 8 | Day-of-week load value |
| load_date_i | input | 8 | Date load value |
| load_month_i | input | 8 | Month load value |
| load_year_i | input | 8 | Year load value |
| sec_o | output | 8 | Seconds, bit 7 is the stop flag |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| day_o | output | 8 | Day of week |
| date_o | output | 8 | Date |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| busy_o | output | 1 | An increment is applied at the next edge |

## Verification
The bench builds the block with STEPS_PER_SEC set to 3, so one simulated second takes a handful of cycles. That makes every month-end rollover, February in leap and common years, and the 99-to-00 year wrap reachable by loading the last second of a period and stepping once. The value 3 also gives a phase that a load or a stop can interrupt part way, so the restart of the one-second phase is visible.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int IDX_SEC    = 0;
  localparam int IDX_MIN    = 1;
  localparam int IDX_HOUR   = 2;
  localparam int IDX_DAY    = 3;
  localparam int IDX_DATE   = 4;
  localparam int IDX_MONTH  = 5;
  localparam int IDX_YEAR   = 6;

  typedef logic [7:0] bcd8_t;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // tens even: units 0/4/8; tens odd: units 2/6
  function automatic logic year_is_leap(bcd8_t y);
    return y[1:0] == {y[4], 1'b0};
  endfunction

  function automatic bcd8_t month_last_date(bcd8_t m, logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd8_t field_lo(int i);
    return (i == IDX_DAY || i == IDX_DATE || i == IDX_MONTH) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd8_t field_hi(int i);
    case (i)
      IDX_SEC, IDX_MIN: return 8'h59;
      IDX_HOUR:         return 8'h23;
      IDX_DAY:          return 8'h07;
      IDX_DATE:         return 8'h31;
      IDX_MONTH:        return 8'h12;
      default:          return 8'h99;
    endcase
  endfunction

  function automatic bcd8_t field_mask(int i);
    case (i)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR:         return 8'h3F;
      IDX_DAY:          return 8'h07;
      IDX_DATE:         return 8'h3F;
      IDX_MONTH:        return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sec_phase.sv
module rtc_sec_phase #(
  parameter int STEPS_PER_SEC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clear_i,
  output logic due_o
);
  localparam int PW = (STEPS_PER_SEC > 1) ? $clog2(STEPS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(STEPS_PER_SEC - 1);

  logic [PW-1:0] ph_q;
  logic          due_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      due_q <= 1'b0;
    end else if (clear_i) begin
      ph_q  <= '0;
      due_q <= 1'b0;
    end else begin
      due_q <= step_i && (ph_q == LAST);
      if (step_i) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign due_o = due_q;
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
(
  input  bcd8_t value_i,
  input  bcd8_t lo_i,
  input  bcd8_t hi_i,
  output bcd8_t next_o,
  output logic  wrap_o
);
  // >= so an out-of-range value (e.g. date past month end) still wraps
  assign wrap_o = (value_i >= hi_i);
  assign next_o = wrap_o ? lo_i : bcd_inc(value_i);
endmodule

// File: rtl/rtc_month_end.sv
module rtc_month_end
  import rtc_cal_pkg::*;
(
  input  bcd8_t month_i,
  input  bcd8_t year_i,
  output bcd8_t last_o
);
  assign last_o = month_last_date(month_i, year_is_leap(year_i));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int STEPS_PER_SEC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       load_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hour_i,
  input  logic [7:0] load_day_i,
  input  logic [7:0] load_date_i,
  input  logic [7:0] load_month_i,
  input  logic [7:0] load_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       busy_o
);
  bcd8_t fld_q  [NUM_FIELDS];
  bcd8_t ld_w   [NUM_FIELDS];
  bcd8_t next_w [NUM_FIELDS];
  bcd8_t hi_w   [NUM_FIELDS];
  logic  wrap_w [NUM_FIELDS];
  logic  en_w   [NUM_FIELDS];
  logic  stop_q;
  logic  due_w;
  bcd8_t last_w;
  logic  unused_wrap;

  assign ld_w[IDX_SEC]   = load_sec_i;
  assign ld_w[IDX_MIN]   = load_min_i;
  assign ld_w[IDX_HOUR]  = load_hour_i;
  assign ld_w[IDX_DAY]   = load_day_i;
  assign ld_w[IDX_DATE]  = load_date_i;
  assign ld_w[IDX_MONTH] = load_month_i;
  assign ld_w[IDX_YEAR]  = load_year_i;

  rtc_sec_phase #(.STEPS_PER_SEC(STEPS_PER_SEC)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .clear_i(load_i | stop_q),
    .due_o  (due_w)
  );

  rtc_month_end i_month_end (
    .month_i(fld_q[IDX_MONTH]),
    .year_i (fld_q[IDX_YEAR]),
    .last_o (last_w)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    if (i == IDX_DATE) begin : g_hi_date
      assign hi_w[i] = last_w;
    end else begin : g_hi_fix
      assign hi_w[i] = field_hi(i);
    end

    // day and date both take the hour carry
    if (i == 0) begin : g_en_sec
      assign en_w[i] = due_w;
    end else if (i == IDX_DATE) begin : g_en_date
      assign en_w[i] = en_w[i-1];
    end else begin : g_en_chain
      assign en_w[i] = en_w[i-1] & wrap_w[i-1];
    end

    rtc_bcd_field i_field (
      .value_i(fld_q[i]),
      .lo_i   (field_lo(i)),
      .hi_i   (hi_w[i]),
      .next_o (next_w[i]),
      .wrap_o (wrap_w[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       fld_q[i] <= field_lo(i);
      else if (load_i)   fld_q[i] <= ld_w[i] & field_mask(i);
      else if (en_w[i])  fld_q[i] <= next_w[i];
    end
  end

  assign unused_wrap = wrap_w[IDX_DAY] ^ wrap_w[IDX_YEAR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stop_q <= 1'b1;
    else if (load_i) stop_q <= load_sec_i[7];
  end

  assign sec_o   = {stop_q, fld_q[IDX_SEC][6:0]};
  assign min_o   = fld_q[IDX_MIN];
  assign hour_o  = fld_q[IDX_HOUR];
  assign day_o   = fld_q[IDX_DAY];
  assign date_o  = fld_q[IDX_DATE];
  assign month_o = fld_q[IDX_MONTH];
  assign year_o  = fld_q[IDX_YEAR];
  assign busy_o  = due_w;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] day_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       busy_o
);
  assert_busy_moves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !load_i |=> sec_o != $past(sec_o));

  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !load_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(day_o) && $stable(date_o) && $stable(month_o) && $stable(year_o));

  assert_stop_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o[7] |-> !busy_o);

  assert_hour_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !load_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23
    |=> hour_o == 8'h00 && day_o != $past(day_o));

  assert_year_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !load_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
    date_o == 8'h31 && month_o == 8'h12 && year_o == 8'h99
    |=> year_o == 8'h00 && month_o == 8'h01 && date_o == 8'h01);

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_o[7] == 1'b0 && hour_o[7:6] == 2'b0 && day_o[7:3] == 5'b0 &&
    date_o[7:6] == 2'b0 && month_o[7:5] == 3'b0);
endmodule

bind rtc_bcd_calendar rtc_calendar_chk i_rtc_calendar_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .sec_o  (sec_o),
  .min_o  (min_o),
  .hour_o (hour_o),
  .day_o  (day_o),
  .date_o (date_o),
  .month_o(month_o),
  .year_o (year_o),
  .busy_o (busy_o)
);

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 3;

  typedef struct packed {
    logic [7:0] yr, mo, dt, dw, hr, mi, se;
  } cal_t;

  logic clk = 0, rst_n = 0, step = 0, load = 0;
  cal_t ld = '0;
  logic [7:0] sec, min, hour, day, date, month, year;
  logic busy;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_calendar #(.STEPS_PER_SEC(STEPS)) i_rtc_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .load_i(load),
    .load_sec_i(ld.se), .load_min_i(ld.mi), .load_hour_i(ld.hr),
    .load_day_i(ld.dw), .load_date_i(ld.dt), .load_month_i(ld.mo),
    .load_year_i(ld.yr),
    .sec_o(sec), .min_o(min), .hour_o(hour), .day_o(day), .date_o(date),
    .month_o(month), .year_o(year), .busy_o(busy)
  );

  function automatic int b2i(logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int last_day(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic cal_t mk(int y, int mo, int d, int w, int h, int m, int s);
    return {i2b(y), i2b(mo), i2b(d), i2b(w), i2b(h), i2b(m), i2b(s)};
  endfunction

  function automatic cal_t model_next(cal_t c);
    int s = b2i({1'b0, c.se[6:0]}), m = b2i(c.mi), h = b2i(c.hr);
    int w = b2i(c.dw), d = b2i(c.dt), mo = b2i(c.mo), y = b2i(c.yr);
    s++;
    if (s > 59) begin s = 0; m++; end
    if (m > 59) begin m = 0; h++; end
    if (h > 23) begin
      h = 0;
      w = (w >= 7) ? 1 : w + 1;
      if (d >= last_day(mo, y)) begin
        d = 1; mo++;
        if (mo > 12) begin mo = 1; y = (y >= 99) ? 0 : y + 1; end
      end else d++;
    end
    return mk(y, mo, d, w, h, m, s);
  endfunction

  function automatic cal_t cur();
    return {year, month, date, day, hour, min, sec};
  endfunction

  task automatic check_cal(cal_t exp, string req);
    n_run++;
    if (cur() !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, cur(), exp);
    end
  endtask

  task automatic check_bit(logic act, logic exp, string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %b exp %b", req, act, exp);
    end
  endtask

  task automatic do_load(cal_t v);
    @(negedge clk); ld = v; load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic pulse_steps(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); step = 1;
      @(negedge clk); step = 0;
    end
  endtask

  // one second: busy shows for one cycle, then fields move
  task automatic advance_check(cal_t start, string req);
    pulse_steps(STEPS);
    check_bit(busy, 1'b1, "R9 busy before update");
    @(negedge clk);
    check_bit(busy, 1'b0, "R9 busy one cycle");
    check_cal(model_next(start), req);
  endtask

  task automatic month_end(int mo, int y);
    cal_t c = mk(y, mo, last_day(mo, y), 7, 23, 59, 59);
    do_load(c);
    advance_check(c, "R4/R3 month end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cal_t c, z;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_cal({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80}, "R1 reset");
    check_bit(busy, 1'b0, "R1 busy reset");
    // R7 stopped after reset: strobes do nothing
    pulse_steps(STEPS * 2);
    @(negedge clk);
    check_cal({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80}, "R7 stop after reset");

    // R2 plain seconds and minute carry
    c = mk(23, 5, 10, 3, 8, 14, 7);  do_load(c); advance_check(c, "R2 seconds");
    c = mk(23, 5, 10, 3, 8, 14, 59); do_load(c); advance_check(c, "R2 minute carry");
    c = mk(23, 5, 10, 3, 8, 59, 59); do_load(c); advance_check(c, "R2 hour carry");
    // R3 day wrap not at month end
    c = mk(23, 5, 10, 7, 23, 59, 59); do_load(c); advance_check(c, "R3 day 07->01");
    c = mk(23, 5, 10, 4, 23, 59, 59); do_load(c); advance_check(c, "R3 day incr");

    // R4 every month end, common year and leap year
    for (int mo = 1; mo <= 12; mo++) begin
      month_end(mo, 23);
      month_end(mo, 24);
    end
    // R5 leap rule across tens parity
    c = mk(24, 2, 28, 1, 23, 59, 59); do_load(c); advance_check(c, "R5 leap 24 feb28");
    c = mk(12, 2, 28, 1, 23, 59, 59); do_load(c); advance_check(c, "R5 leap 12 feb28");
    c = mk(0, 2, 28, 1, 23, 59, 59);  do_load(c); advance_check(c, "R5 leap 00 feb28");
    c = mk(14, 2, 28, 1, 23, 59, 59); do_load(c); advance_check(c, "R5 common 14 feb28");
    c = mk(98, 2, 28, 1, 23, 59, 59); do_load(c); advance_check(c, "R5 common 98 feb28");
    // R6 year wrap
    c = mk(99, 12, 31, 5, 23, 59, 59); do_load(c); advance_check(c, "R6 year 99->00");
    // R4 date above month end wraps
    c = mk(23, 4, 31, 2, 23, 59, 59); do_load(c); advance_check(c, "R4 date past end");

    // R8 upper bits cleared on load
    z = mk(23, 6, 1, 1, 0, 0, 0);
    z.hr = 8'hD5; z.mi = 8'h92; z.dw = 8'hF3; z.dt = 8'hC9; z.mo = 8'hE7;
    do_load(z);
    check_cal({8'h23, 8'h07, 8'h09, 8'h03, 8'h15, 8'h12, 8'h00}, "R8 load mask");

    // R8 load restarts the phase
    c = mk(30, 8, 15, 2, 10, 20, 30); do_load(c);
    pulse_steps(STEPS - 1);
    c = mk(31, 9, 16, 3, 11, 21, 31); do_load(c);
    pulse_steps(STEPS - 1);
    @(negedge clk);
    check_cal(c, "R8 phase restart no early tick");
    pulse_steps(1);
    check_bit(busy, 1'b1, "R8 busy after full second");
    @(negedge clk);
    check_cal(model_next(c), "R8 first increment");

    // R8 load wins over pending increment
    c = mk(40, 3, 3, 3, 3, 3, 3); do_load(c);
    pulse_steps(STEPS);
    z = mk(41, 4, 4, 4, 4, 4, 4);
    ld = z; load = 1;
    @(negedge clk); load = 0;
    check_cal(z, "R8 load over pending");
    check_bit(busy, 1'b0, "R8 pending dropped");

    // R7 stop holds; R10 resume one second after clear
    c = mk(50, 1, 20, 6, 12, 30, 45); c.se[7] = 1'b1; do_load(c);
    pulse_steps(STEPS * 2);
    check_bit(busy, 1'b0, "R7 no busy while stopped");
    @(negedge clk);
    check_cal(c, "R7 frozen");
    pulse_steps(STEPS - 1);
    c.se[7] = 1'b0; do_load(c);
    pulse_steps(STEPS - 1);
    @(negedge clk);
    check_cal(c, "R10 no early resume");
    pulse_steps(1);
    check_bit(busy, 1'b1, "R10 busy after resume");
    @(negedge clk);
    check_cal(model_next(c), "R10 resumed");

    // random valid states, biased towards carries
    for (int i = 0; i < 60; i++) begin
      int y = int'($urandom % 100), mo = 1 + int'($urandom % 12);
      int d = 1 + int'($urandom % last_day(mo, y));
      int s = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      int m = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      int h = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
      if ($urandom % 3 == 0) d = last_day(mo, y);
      c = mk(y, mo, d, 1 + int'($urandom % 7), h, m, s);
      do_load(c);
      advance_check(c, "R2/R3/R4/R5/R6 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule